// File: doc/BRIEF.md
# Latched-Address Synchronous Read-Only Store

This block models a 2048-word by 8-bit one-time-programmable read-only memory with a synchronous access style. The chip-enable strobe is active low. When it goes from high to low, the block captures the address into an internal register. After that capture, the address bus may change freely until the next strobe. A separate active-low output enable gates the data outputs. The output enable takes effect only after it has been armed by its own high-to-low transition. A program-enable input must stay high for reads.

The block treats both strobes as ordinary inputs and samples them on a system clock, so every edge of the strobes is seen at a clock edge. The contents come from a parameter array and default to all zero. Inside, the store is a 128 by 128 bit matrix. The upper seven address bits select one row. The lower four bits pick one of 16 columns in each of the 8 output-bit groups. The data output drives zero whenever the drive-enable vector is low, so the three-state buffer can sit outside the block.

Top module: `latched_prom`

## Requirements
- R1: After an access has been opened at address a, with the output enable armed and program enable high, q_o equals INIT_WORDS[a] and q_en_o is all ones. This holds for every address, including row and column boundaries (0, 15, 16, 127, 128, 2047).
- R2: With INIT_WORDS left at its default, every enabled read returns 8'h00.
- R3: addr_i is captured only at a clock edge where ce_ni is sampled low and was sampled high at the previous edge. Changes on addr_i while ce_ni stays low do not change q_o.
- R4: A capture made while oe_ni is high gives no output. When oe_ni later falls, the captured word appears one edge later.
- R5: If oe_ni is sampled high, q_en_o is 0 after that edge. Re-enabling requires a sampled high-to-low transition of oe_ni.
- R6: If ce_ni is sampled high, the access ends: q_en_o is 0 after that edge, and it stays 0 until the next capture.
- R7: A ce_ni fall sampled while the output enable is armed shows the newly captured word after that same edge, with no stale word in between.
- R8: If pgm_ni is sampled low, q_en_o is 0 after that edge. Reads resume once pgm_ni is sampled high again.
- R9: During and after the asynchronous reset, q_en_o is 0 and q_o is 0 until the first ce_ni fall. The reset value of the previous-sample registers is high, so a strobe low at the first edge after reset counts as a fall.
- R10: q_en_o is always either all zeros or all ones, and q_o is 8'h00 whenever q_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 11 | Word address, captured on a chip-enable fall |
| ce_ni | input | 1 | Active-low chip enable; a fall captures, high ends the access |
| oe_ni | input | 1 | Active-low output enable, armed by its fall |
| pgm_ni | input | 1 | Active-low program enable, held high for reads |
| q_o | output | 8 | Read data, zero when not driven |
| q_en_o | output | 8 | Per-bit drive enable for an external three-state buffer |

## Verification
Every result is due exactly one rising clock edge after the inputs that cause it. The inputs are registered once, and the read path from the captured address to q_o is combinational. The driver applies each input set on a falling clock edge. It then pushes the expected drive enable and word for the next rising edge into a queue. The monitor pops that entry 1 ns after the rising edge and compares it there.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int unsigned PROM_AW    = 11;
  localparam int unsigned PROM_DW    = 8;
  localparam int unsigned PROM_ROW_W = 7;
  typedef logic [PROM_DW-1:0] prom_image_t [1 << PROM_AW];
endpackage

// File: rtl/prom_addr_latch.sv
module prom_addr_latch #(
  parameter int unsigned AW = prom_pkg::PROM_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_ni,
  output logic [AW-1:0] addr_q_o,
  output logic          valid_o
);
  logic          ce_d_q;
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          ce_fall;

  assign ce_fall = !ce_ni && ce_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_d_q  <= 1'b1;
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      ce_d_q <= ce_ni;
      if (ce_fall) begin
        addr_q  <= addr_i;
        valid_q <= 1'b1;
      end else if (ce_ni) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign addr_q_o = addr_q;
  assign valid_o  = valid_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || !ce_d_q) |=> $stable(addr_q)); // R3
  AST_RISE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !valid_q); // R6
endmodule

// File: rtl/prom_bit_matrix.sv
module prom_bit_matrix #(
  parameter int unsigned AW    = prom_pkg::PROM_AW,
  parameter int unsigned DW    = prom_pkg::PROM_DW,
  parameter int unsigned ROW_W = prom_pkg::PROM_ROW_W,
  parameter logic [DW-1:0] INIT_WORDS [1 << AW] = '{default: '0}
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] word_o
);
  localparam int unsigned COL_W = AW - ROW_W;
  localparam int unsigned NCOL  = 1 << COL_W;
  localparam int unsigned NROW  = 1 << ROW_W;
  localparam int unsigned RW    = DW * NCOL;

  // group g, column c of row r holds bit g of word {r, c}
  function automatic logic [RW-1:0] pack_row(input int unsigned r);
    logic [RW-1:0] b;
    b = '0;
    for (int unsigned g = 0; g < DW; g++)
      for (int unsigned c = 0; c < NCOL; c++)
        b[g*NCOL + c] = INIT_WORDS[r*NCOL + c][g];
    return b;
  endfunction

  logic [RW-1:0]    row_bits [NROW];
  logic [NROW-1:0]  row_sel;
  logic [RW-1:0]    row_word;
  logic [ROW_W-1:0] row_idx;
  logic [COL_W-1:0] col_idx;

  assign row_idx = addr_i[AW-1:COL_W];
  assign col_idx = addr_i[COL_W-1:0];

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign row_bits[r] = pack_row(r);
  end

  always_comb begin
    row_sel = '0;
    row_sel[row_idx] = 1'b1;
  end

  always_comb begin
    row_word = '0;
    for (int unsigned r = 0; r < NROW; r++)
      row_word |= row_bits[r] & {RW{row_sel[r]}};
  end

  for (genvar g = 0; g < DW; g++) begin : g_col
    logic [NCOL-1:0] grp;
    assign grp       = row_word[g*NCOL +: NCOL];
    assign word_o[g] = grp[col_idx];
  end
endmodule

// File: rtl/prom_out_gate.sv
module prom_out_gate #(
  parameter int unsigned DW = prom_pkg::PROM_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          oe_ni,
  input  logic          pgm_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] q_en_o
);
  logic oe_d_q;
  logic armed_q;
  logic pgm_q;
  logic drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_d_q  <= 1'b1;
      armed_q <= 1'b0;
      pgm_q   <= 1'b1;
    end else begin
      oe_d_q <= oe_ni;
      pgm_q  <= pgm_ni;
      if (oe_ni)       armed_q <= 1'b0;
      else if (oe_d_q) armed_q <= 1'b1;
    end
  end

  assign drive  = valid_i && armed_q && pgm_q;
  assign q_o    = drive ? word_i : '0;
  assign q_en_o = {DW{drive}};

  AST_G_HIGH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> (q_en_o == '0)); // R5
  AST_P_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_ni |=> (q_en_o == '0)); // R8
  AST_OFF_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_en_o != '1) |-> (q_en_o == '0 && q_o == '0)); // R10
endmodule

// File: rtl/latched_prom.sv
module latched_prom #(
  parameter int unsigned AW    = prom_pkg::PROM_AW,
  parameter int unsigned DW    = prom_pkg::PROM_DW,
  parameter int unsigned ROW_W = prom_pkg::PROM_ROW_W,
  parameter logic [DW-1:0] INIT_WORDS [1 << AW] = '{default: '0}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          pgm_ni,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] q_en_o
);
  logic [AW-1:0] addr_q;
  logic          valid;
  logic [DW-1:0] word;

  prom_addr_latch #(.AW(AW)) i_latch (
    .clk_i, .rst_ni, .addr_i, .ce_ni,
    .addr_q_o(addr_q), .valid_o(valid)
  );

  prom_bit_matrix #(.AW(AW), .DW(DW), .ROW_W(ROW_W), .INIT_WORDS(INIT_WORDS)) i_matrix (
    .addr_i(addr_q), .word_o(word)
  );

  prom_out_gate #(.DW(DW)) i_gate (
    .clk_i, .rst_ni, .oe_ni, .pgm_ni,
    .valid_i(valid), .word_i(word), .q_o, .q_en_o
  );

  AST_CE_HIGH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (q_en_o == '0)); // R6
endmodule

// File: tb/test_latched_prom.sv
`timescale 1ns/100ps
module test_latched_prom;
  import prom_pkg::*;

  function automatic prom_image_t make_img();
    prom_image_t m;
    for (int a = 0; a < (1 << PROM_AW); a++)
      m[a] = 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
    return m;
  endfunction

  localparam prom_image_t IMG = make_img();

  typedef struct {
    logic       en;
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [PROM_AW-1:0] addr_i = '0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, pgm_ni = 1'b1;
  logic [7:0] q_o, q_en_o, qb_o, qb_en_o;

  int n_cmp = 0, n_bad = 0;
  bit run_mon = 0, done = 0;
  exp_t exp_q[$];

  // bench-side model state
  bit m_ce_d, m_oe_d, m_valid, m_armed, m_pgm;
  logic [PROM_AW-1:0] m_addr;

  always #2.5 clk_i = ~clk_i;

  latched_prom #(.INIT_WORDS(IMG)) i_latched_prom (
    .clk_i, .rst_ni, .addr_i, .ce_ni, .oe_ni, .pgm_ni, .q_o, .q_en_o
  );

  latched_prom i_blank (
    .clk_i, .rst_ni, .addr_i, .ce_ni, .oe_ni, .pgm_ni, .q_o(qb_o), .q_en_o(qb_en_o)
  );

  task automatic check(input string tag, input logic [7:0] act_en, input logic [7:0] act_q,
                       input logic [7:0] exp_en, input logic [7:0] exp_d);
    n_cmp++;
    if (act_en !== exp_en || act_q !== exp_d) begin
      n_bad++;
      $display("FAIL %s: en=%h q=%h expected en=%h q=%h", tag, act_en, act_q, exp_en, exp_d);
    end
  endtask

  task automatic step(input logic [PROM_AW-1:0] a, input bit ce, input bit oe, input bit pg,
                      input string tag);
    exp_t e;
    @(negedge clk_i);
    addr_i = a; ce_ni = ce; oe_ni = oe; pgm_ni = pg;
    if (!ce && m_ce_d) begin m_addr = a; m_valid = 1; end
    else if (ce) m_valid = 0;
    if (oe) m_armed = 0; else if (m_oe_d) m_armed = 1;
    m_ce_d = ce; m_oe_d = oe; m_pgm = pg;
    e.en   = m_valid && m_armed && m_pgm;
    e.data = e.en ? IMG[m_addr] : 8'h00;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (run_mon && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.tag, q_en_o, q_o, {8{e.en}}, e.data);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: en=%h q=%h expected run to finish", q_en_o, q_o);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] lfsr;
    logic [PROM_AW-1:0] bnd [10];
    bnd = '{11'd0, 11'd15, 11'd16, 11'd127, 11'd128, 11'd1023, 11'd1024, 11'd2032, 11'd2046, 11'd2047};
    repeat (3) @(posedge clk_i);
    #1;
    check("R9 reset", q_en_o, q_o, 8'h00, 8'h00);
    m_ce_d = 1; m_oe_d = 1; m_valid = 0; m_armed = 0; m_pgm = 1; m_addr = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_mon = 1;

    step(11'd5, 1, 0, 1, "R9 no capture yet");
    step(11'd5, 0, 0, 1, "R7 fall with G low");
    step(11'd100, 0, 0, 1, "R3 address ignored");
    step(11'd200, 0, 0, 1, "R3 address ignored");
    step(11'd9, 1, 0, 1, "R6 access ends");
    step(11'd9, 1, 0, 1, "R6 stays off");
    step(11'd2047, 0, 0, 1, "R7 new word at once");
    step(11'd3, 0, 1, 1, "R5 G high off");
    step(11'd3, 0, 0, 1, "R5 rearm on G fall");
    step(11'd3, 0, 0, 0, "R8 P low off");
    step(11'd3, 0, 0, 1, "R8 P high resumes");
    step(11'd700, 1, 1, 1, "R6 close");
    step(11'd700, 0, 1, 1, "R4 capture with G high");
    step(11'd44, 0, 1, 1, "R4 still off");
    step(11'd44, 0, 0, 1, "R4 G fall shows word");
    foreach (bnd[i]) begin
      step(bnd[i], 1, 0, 1, "R1 close");
      step(bnd[i], 0, 0, 1, "R1 boundary read");
    end
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[10:0], lfsr[11] & lfsr[12], lfsr[13] & lfsr[14], lfsr[15] | lfsr[3], "R10 mixed");
    end
    step(11'd77, 1, 0, 1, "R1 close");
    step(11'd77, 0, 0, 1, "R1 final read");
    repeat (3) @(posedge clk_i);
    #1;
    check("R2 blank store", qb_en_o, qb_o, 8'hFF, 8'h00);
    check("R1 held read", q_en_o, q_o, 8'hFF, IMG[77]);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule